// File: doc/BRIEF.md
# Status Flag and Branch Condition Unit

This block holds the carry, zero and negative status flags of a small microcoded 8-bit processor. It also produces one condition bit that the next-address logic uses to pick the following microinstruction. Each flag has its own update enable, taken from the registered microinstruction. When its enable is set, a flag loads its value from the ALU: the carry-out, a zero test of the result, or the sign bit of the result.

The 3-bit condition select and its write strobe come straight from the microcode ROM output, ahead of the microinstruction register. The condition bit is therefore loaded at the same edge that loads the next microinstruction. This saves one cycle on every conditional micro-step: the test is made while the next word is fetched, and the word after that can already depend on the result. A build parameter can instead place a register stage in front of the select, which gives the slower three-cycle sequence.

The flags are never read or written as a whole byte. Push and pull microcode moves them one at a time through a single-bit write port and a single-bit read port.

Top module: `flag_cond_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the C, Z and N flags, the condition bit and any staged select at the next rising edge.
- R2: At a rising edge with `upd_c` high, `flag_c` loads `alu_cout`. With `upd_c` low (and no direct write to C), `flag_c` keeps its value.
- R3: At a rising edge with `upd_z` high, `flag_z` loads 1 when `alu_res` is all zeros and 0 otherwise. With `upd_z` low, it holds.
- R4: At a rising edge with `upd_n` high, `flag_n` loads the top bit of `alu_res` (bit 7 by default). With `upd_n` low, it holds.
- R5: The select codes are 0 = C, 1 = Z, 2 = N, 3 = constant 1, 4 = not C, 5 = not Z, 6 = not N and 7 = constant 0.
- R6: With the early variant, `cond_f` takes the value selected by `rom_csel` at the rising edge that ends the cycle in which `rom_cwr` is high. While `rom_cwr` is low, `cond_f` holds.
- R7: With `EARLY_EVAL` = 0, the select and strobe pass through one register first, so `cond_f` changes exactly one edge later than in the early variant.
- R8: When `wr_en` is high, `wr_sel` picks the flag that loads `wr_val` (0 = C, 1 = Z, 2 = N). This write wins over an ALU update of the same flag. `wr_sel` = 3 changes no flag.
- R9: `rd_bit` shows, without delay, C, Z, N or `cond_f` for `rd_sel` values 0, 1, 2 and 3.
- R10: A condition written at the same edge as a flag update uses the flag values from before that edge. Loading the condition does not block any flag update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_c | input | 1 | Carry update enable (registered microinstruction) |
| upd_z | input | 1 | Zero update enable (registered microinstruction) |
| upd_n | input | 1 | Negative update enable (registered microinstruction) |
| alu_cout | input | 1 | ALU carry-out |
| alu_res | input | DATA_W | ALU result |
| rom_csel | input | 3 | Condition select from the ROM output |
| rom_cwr | input | 1 | Condition write strobe from the ROM output |
| wr_en | input | 1 | Single-flag write enable |
| wr_sel | input | 2 | Flag picked for the single-flag write |
| wr_val | input | 1 | Value for the single-flag write |
| rd_sel | input | 2 | Source picked for the single-bit read |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| cond_f | output | 1 | Condition bit for the next-address logic |
| rd_bit | output | 1 | Single-bit read result |

## Verification
The bench builds two copies side by side, both with an 8-bit result. One uses `EARLY_EVAL` = 1 and the other uses `EARLY_EVAL` = 0. Both get the same stimulus. This lets the bench measure the one-edge lead of the early path on the same flag history, and it reaches both branches of the select-stage generate. The 8-bit width puts the sign flag on bit 7, and random results regularly hit the all-zero value that drives the zero detector.

// File: rtl/flag_cond_pkg.sv
package flag_cond_pkg;
  localparam int NUM_FLAGS = 3;

  typedef enum logic [1:0] {
    FL_C    = 2'd0,
    FL_Z    = 2'd1,
    FL_N    = 2'd2,
    FL_NONE = 2'd3
  } flag_idx_e;

  typedef enum logic [2:0] {
    CS_C    = 3'd0,
    CS_Z    = 3'd1,
    CS_N    = 3'd2,
    CS_ONE  = 3'd3,
    CS_NC   = 3'd4,
    CS_NZ   = 3'd5,
    CS_NN   = 3'd6,
    CS_ZERO = 3'd7
  } cond_sel_e;

  // Condition evaluation from the three status flags.
  function automatic logic cond_eval(input logic [2:0] sel, input logic c,
                                     input logic z, input logic n);
    logic r;
    case (cond_sel_e'(sel))
      CS_C:    r = c;
      CS_Z:    r = z;
      CS_N:    r = n;
      CS_ONE:  r = 1'b1;
      CS_NC:   r = ~c;
      CS_NZ:   r = ~z;
      CS_NN:   r = ~n;
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/flag_bank.sv
module flag_bank
  import flag_cond_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] upd,
  input  logic                 alu_cout,
  input  logic [DATA_W-1:0]    alu_res,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic                 wr_val,
  output logic [NUM_FLAGS-1:0] flags
);
  localparam int SIGN_BIT = DATA_W - 1;

  function automatic logic is_zero(input logic [DATA_W-1:0] v);
    return (v == '0);
  endfunction

  logic [NUM_FLAGS-1:0] alu_bits;
  logic [NUM_FLAGS-1:0] hit;
  logic [NUM_FLAGS-1:0] flags_next;

  assign alu_bits[FL_C] = alu_cout;
  assign alu_bits[FL_Z] = is_zero(alu_res);
  assign alu_bits[FL_N] = alu_res[SIGN_BIT];

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    assign hit[g] = wr_en && (wr_sel == 2'(g));
    assign flags_next[g] = hit[g] ? wr_val : (upd[g] ? alu_bits[g] : flags[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags_next;
  end

  // R2
  c_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd[FL_C] && !hit[FL_C]) |=> $stable(flags[FL_C]));
  // R2
  c_load_chk: assert property (@(posedge clk) disable iff (rst)
    (upd[FL_C] && !hit[FL_C]) |=> flags[FL_C] == $past(alu_cout));
  // R3
  z_load_chk: assert property (@(posedge clk) disable iff (rst)
    (upd[FL_Z] && !hit[FL_Z]) |=> flags[FL_Z] == ($past(alu_res) == '0));
  // R4
  n_load_chk: assert property (@(posedge clk) disable iff (rst)
    (upd[FL_N] && !hit[FL_N]) |=> flags[FL_N] == $past(alu_res[SIGN_BIT]));
  // R8
  wr_win_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == FL_Z) |=> flags[FL_Z] == $past(wr_val));
  // R8
  none_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == FL_NONE && upd == '0) |=> $stable(flags));
endmodule

// File: rtl/cond_select.sv
module cond_select
  import flag_cond_pkg::*;
(
  input  logic [2:0]           sel,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 cond_next
);
  assign cond_next = cond_eval(sel, flags[FL_C], flags[FL_Z], flags[FL_N]);

  // R5
  always_comb begin
    if (sel == CS_ONE)  const_one_chk:  assert (cond_next == 1'b1);
    if (sel == CS_ZERO) const_zero_chk: assert (cond_next == 1'b0);
  end
endmodule

// File: rtl/cond_reg.sv
module cond_reg #(
  parameter bit EARLY_EVAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_in,
  input  logic       cwr_in,
  input  logic       cond_next,
  output logic [2:0] sel_eff,
  output logic       cwr_eff,
  output logic       cond_f
);
  if (EARLY_EVAL) begin : g_early
    assign sel_eff = sel_in;
    assign cwr_eff = cwr_in;
  end else begin : g_late
    logic [2:0] sel_q;
    logic       cwr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q <= '0;
        cwr_q <= 1'b0;
      end else begin
        sel_q <= sel_in;
        cwr_q <= cwr_in;
      end
    end
    assign sel_eff = sel_q;
    assign cwr_eff = cwr_q;

    // R7
    stage_delay_chk: assert property (@(posedge clk) disable iff (rst)
      cwr_in |=> cwr_q);
  end

  always_ff @(posedge clk) begin
    if (rst)          cond_f <= 1'b0;
    else if (cwr_eff) cond_f <= cond_next;
  end

  // R6
  cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cwr_eff |=> $stable(cond_f));
  // R10
  cond_load_chk: assert property (@(posedge clk) disable iff (rst)
    cwr_eff |=> cond_f == $past(cond_next));
endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import flag_cond_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit EARLY_EVAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_c,
  input  logic              upd_z,
  input  logic              upd_n,
  input  logic              alu_cout,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [2:0]        rom_csel,
  input  logic              rom_cwr,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic              wr_val,
  input  logic [1:0]        rd_sel,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_n,
  output logic              cond_f,
  output logic              rd_bit
);
  logic [NUM_FLAGS-1:0] flags;
  logic [2:0]           sel_eff;
  logic                 cwr_eff;
  logic                 cond_next;

  flag_bank #(.DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .upd      ({upd_n, upd_z, upd_c}),
    .alu_cout (alu_cout),
    .alu_res  (alu_res),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_val   (wr_val),
    .flags    (flags)
  );

  cond_select u_sel (
    .sel       (sel_eff),
    .flags     (flags),
    .cond_next (cond_next)
  );

  cond_reg #(.EARLY_EVAL(EARLY_EVAL)) u_creg (
    .clk       (clk),
    .rst       (rst),
    .sel_in    (rom_csel),
    .cwr_in    (rom_cwr),
    .cond_next (cond_next),
    .sel_eff   (sel_eff),
    .cwr_eff   (cwr_eff),
    .cond_f    (cond_f)
  );

  assign flag_c = flags[FL_C];
  assign flag_z = flags[FL_Z];
  assign flag_n = flags[FL_N];

  always_comb begin
    case (flag_idx_e'(rd_sel))
      FL_C:    rd_bit = flag_c;
      FL_Z:    rd_bit = flag_z;
      FL_N:    rd_bit = flag_n;
      default: rd_bit = cond_f;
    endcase
  end

  // R9
  rd_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == FL_NONE) |-> rd_bit == cond_f);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags == '0 && !cond_f));
endmodule

// File: tb/tb_flag_cond_unit.sv
`timescale 1ns/1ps
module tb_flag_cond_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, upd_c, upd_z, upd_n, alu_cout, rom_cwr, wr_en, wr_val;
  logic [7:0] alu_res;
  logic [2:0] rom_csel;
  logic [1:0] wr_sel, rd_sel;
  logic fc, fz, fn, ff, rb;
  logic lc, lz, ln, lf, lb;

  flag_cond_unit #(.DATA_W(8), .EARLY_EVAL(1'b1)) dut (
    .clk(clk), .rst(rst), .upd_c(upd_c), .upd_z(upd_z), .upd_n(upd_n),
    .alu_cout(alu_cout), .alu_res(alu_res), .rom_csel(rom_csel), .rom_cwr(rom_cwr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val), .rd_sel(rd_sel),
    .flag_c(fc), .flag_z(fz), .flag_n(fn), .cond_f(ff), .rd_bit(rb));

  flag_cond_unit #(.DATA_W(8), .EARLY_EVAL(1'b0)) dut_late (
    .clk(clk), .rst(rst), .upd_c(upd_c), .upd_z(upd_z), .upd_n(upd_n),
    .alu_cout(alu_cout), .alu_res(alu_res), .rom_csel(rom_csel), .rom_cwr(rom_cwr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val), .rd_sel(rd_sel),
    .flag_c(lc), .flag_z(lz), .flag_n(ln), .cond_f(lf), .rd_bit(lb));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // model state
  logic ec, ez, en, ef, el, pcwr;
  logic [2:0] psel;

  function automatic logic ref_cond(input logic [2:0] s, input logic c, z, n);
    logic base;
    logic [2:0] v;
    v = {n, z, c};
    base = (s[1:0] == 2'd3) ? 1'b1 : v[s[1:0]];
    return base ^ s[2];
  endfunction

  function automatic logic ref_read(input logic [1:0] s, input logic c, z, n, f);
    logic [3:0] v;
    v = {f, n, z, c};
    return v[s];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic uc, uz, un, cout, input logic [7:0] res,
                      input logic [2:0] sel, input logic cwr,
                      input logic we, input logic [1:0] ws, input logic wv,
                      input logic [1:0] rs);
    logic nc, nz, nn, nf, nl;
    upd_c = uc; upd_z = uz; upd_n = un; alu_cout = cout; alu_res = res;
    rom_csel = sel; rom_cwr = cwr; wr_en = we; wr_sel = ws; wr_val = wv; rd_sel = rs;
    nc = (we && ws == 2'd0) ? wv : (uc ? cout : ec);
    nz = (we && ws == 2'd1) ? wv : (uz ? (res == 8'h00) : ez);
    nn = (we && ws == 2'd2) ? wv : (un ? res[7] : en);
    nf = cwr  ? ref_cond(sel, ec, ez, en)  : ef;
    nl = pcwr ? ref_cond(psel, ec, ez, en) : el;
    @(posedge clk); #1;
    ec = nc; ez = nz; en = nn; ef = nf; el = nl; pcwr = cwr; psel = sel;
    chk("R2 flag_c", fc, ec);
    chk("R3 flag_z", fz, ez);
    chk("R4 flag_n", fn, en);
    chk("R6 cond_f", ff, ef);
    chk("R7 late cond_f", lf, el);
    chk("R9 rd_bit", rb, ref_read(rs, ec, ez, en, ef));
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 8'h55, 3'd0, 0, 0, 2'd0, 0, 2'd0);
  endtask

  task automatic set_flags(input logic c, z, n);
    step(0, 0, 0, 0, 8'h00, 3'd0, 0, 1, 2'd0, c, 2'd0);
    step(0, 0, 0, 0, 8'h00, 3'd0, 0, 1, 2'd1, z, 2'd0);
    step(0, 0, 0, 0, 8'h00, 3'd0, 0, 1, 2'd2, n, 2'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    upd_c = 1; upd_z = 1; upd_n = 1; alu_cout = 1; alu_res = 8'h80;
    rom_csel = 3'd3; rom_cwr = 1; wr_en = 0; wr_sel = 0; wr_val = 0; rd_sel = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 flag_c", fc, 1'b0);
    chk("R1 flag_z", fz, 1'b0);
    chk("R1 flag_n", fn, 1'b0);
    chk("R1 cond_f", ff, 1'b0);
    chk("R1 late cond_f", lf, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    ec = 0; ez = 0; en = 0; ef = 0; el = 0; pcwr = 0; psel = 0;
    idle();

    // R5 all encodings, flags C=1 Z=0 N=1
    set_flags(1, 0, 1);
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0, 8'h00, 3'(i), 1, 0, 2'd0, 0, 2'd3);
      chk("R5 code C1Z0N1", ff, 8'b0010_1101 >> i);
    end
    set_flags(0, 1, 0);
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0, 8'h00, 3'(i), 1, 0, 2'd0, 0, 2'd3);
      chk("R5 code C0Z1N0", ff, 8'b0101_1010 >> i);
    end

    // R7 early versus staged select: exactly one edge apart
    step(0, 0, 0, 0, 8'h00, 3'd7, 1, 0, 2'd0, 0, 2'd0);
    idle(); idle();
    step(0, 0, 0, 0, 8'h00, 3'd3, 1, 0, 2'd0, 0, 2'd0);
    chk("R7 early at first edge", ff, 1'b1);
    chk("R7 staged not yet", lf, 1'b0);
    idle();
    chk("R7 staged one edge later", lf, 1'b1);

    // R6 strobe low holds the condition even with a select that would change it
    step(0, 0, 0, 0, 8'h00, 3'd7, 0, 0, 2'd0, 0, 2'd0);
    chk("R6 hold without strobe", ff, 1'b1);

    // R8 direct write beats ALU update; code 3 writes nothing
    set_flags(0, 0, 0);
    step(1, 0, 0, 1, 8'h00, 3'd0, 0, 1, 2'd0, 0, 2'd0);
    chk("R8 write wins over carry", fc, 1'b0);
    set_flags(1, 1, 1);
    step(0, 0, 0, 0, 8'h00, 3'd0, 0, 1, 2'd3, 0, 2'd0);
    chk("R8 sel3 keeps C", fc, 1'b1);
    chk("R8 sel3 keeps Z", fz, 1'b1);
    chk("R8 sel3 keeps N", fn, 1'b1);

    // R10 condition uses pre-edge flags while C updates at the same edge
    set_flags(0, 0, 0);
    step(1, 1, 1, 1, 8'h00, 3'd0, 1, 0, 2'd0, 0, 2'd0);
    chk("R10 cond from old C", ff, 1'b0);
    chk("R10 C still updated", fc, 1'b1);
    chk("R10 Z still updated", fz, 1'b1);

    // R3/R4 boundary results
    step(0, 1, 1, 0, 8'h7F, 3'd0, 0, 0, 2'd0, 0, 2'd2);
    chk("R4 0x7F sign clear", fn, 1'b0);
    chk("R3 0x7F nonzero", fz, 1'b0);
    step(0, 1, 1, 0, 8'h80, 3'd0, 0, 0, 2'd0, 0, 2'd1);
    chk("R4 0x80 sign set", fn, 1'b1);

    // random mix against the bench model
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] r;
      r = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), r,
           3'($urandom), 1'($urandom), ($urandom % 4 == 0), 2'($urandom),
           1'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule